// File: doc/BRIEF.md
# 100BASE-X Receive Code-Group Decoder

This block sits after symbol alignment and descrambling in a 100 Mb/s receive path. Each cycle in which its strobe is high, it takes one aligned 5-bit code-group. It produces media-independent receive signals: a 4-bit nibble, a data-valid flag and an error flag. All three are registered and change only one clock after a strobed code-group, so the nibble rate is the symbol rate.

A small state machine tracks the stream. It searches for the two-symbol start delimiter (J then K) and delivers data code-groups as nibbles. It closes the frame on the two-symbol end delimiter (T then R), which is never passed on as data. A broken start delimiter is reported with a fixed error nibble and data-valid low. An unexpected code-group inside a frame raises the error flag next to data-valid. A premature IDLE inside a frame aborts the frame.

Top module: `rx100_symbol_decoder`

## Requirements
- R1: While reset is held and after it is released, before any strobed code-group, rx_dv, rx_er and rx_nib are all zero.
- R2: Inside a frame, each data code-group drives rx_dv=1, rx_er=0 and its nibble. The code-groups for nibbles 0 to F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100 and 11101.
- R3: In the hunt state, J (11000) gives an output slot with rx_dv=0 and rx_er=0. When K (10001) follows J, its slot carries rx_dv=1, rx_er=0 and rx_nib=0101, and the frame begins.
- R4: A bad start delimiter gives rx_er=1, rx_dv=0 and rx_nib=1110, and the block stays in or returns to the hunt state. A bad start delimiter is either J followed by anything other than K, or any code-group other than IDLE (11111) or J while hunting.
- R5: Inside a frame, any code-group that is neither data, T (01101) nor IDLE gives rx_dv=1 and rx_er=1, with an unspecified nibble. The frame continues, so a following data code-group is delivered normally.
- R6: T inside a frame gives a slot with rx_dv=0 and rx_er=0. When R (00111) follows, its slot also has rx_dv=0 and rx_er=0, and the block returns to the hunt state without delivering either symbol as data.
- R7: If T is followed by any code-group other than R, that slot gives rx_er=1, rx_dv=0 and rx_nib=0000, and the block returns to the hunt state.
- R8: IDLE inside a frame, with no T/R before it, gives rx_dv=1 and rx_er=1, and the block returns to the hunt state. Later data code-groups are then not delivered.
- R9: Outputs update only in the clock after a cycle with sym_vld high, and they hold their values while sym_vld is low.
- R10: IDLE received while hunting gives rx_dv=0, rx_er=0 and rx_nib=0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_vld | input | 1 | Strobe: sym_in holds a code-group this cycle |
| sym_in | input | 5 | Aligned 5-bit code-group |
| rx_nib | output | 4 | Received nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |

## Verification
Several rules are checked by assertions on every cycle. Outputs hold while no code-group is strobed. A rising data-valid always carries the 0101 start nibble without error. A broken start delimiter always yields the 1110 error nibble with data-valid low. A completed end delimiter leaves both flags low. Other behaviour can only be shown by the directed scenarios, because it depends on what comes after a given symbol. These are the full data mapping, the frame continuing after an in-frame error, and the return to the hunt state after a bad end delimiter or a premature IDLE, which shows up in how the next code-group is treated.

// File: rtl/rx100_pkg.sv
package rx100_pkg;

   typedef enum logic [1:0] {
      ST_HUNT,
      ST_SSD2,
      ST_BODY,
      ST_ESD2
   } rx_state_e;

   typedef enum logic [2:0] {
      CG_DATA,
      CG_J,
      CG_K,
      CG_T,
      CG_R,
      CG_IDLE,
      CG_BAD
   } cg_class_e;

   localparam logic [4:0] CODE_J    = 5'b11000;
   localparam logic [4:0] CODE_K    = 5'b10001;
   localparam logic [4:0] CODE_T    = 5'b01101;
   localparam logic [4:0] CODE_R    = 5'b00111;
   localparam logic [4:0] CODE_IDLE = 5'b11111;

   function automatic logic [4:0] data_code(input int unsigned n);
      logic [4:0] c;
      case (n)
         0:  c = 5'b11110;
         1:  c = 5'b01001;
         2:  c = 5'b10100;
         3:  c = 5'b10101;
         4:  c = 5'b01010;
         5:  c = 5'b01011;
         6:  c = 5'b01110;
         7:  c = 5'b01111;
         8:  c = 5'b10010;
         9:  c = 5'b10011;
         10: c = 5'b10110;
         11: c = 5'b10111;
         12: c = 5'b11010;
         13: c = 5'b11011;
         14: c = 5'b11100;
         default: c = 5'b11101;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/rx100_cg_classify.sv
module rx100_cg_classify
   import rx100_pkg::*;
#(
   parameter int SYM_W = 5,
   parameter int NIB_W = 4
)(
   input  logic [SYM_W-1:0] sym,
   output cg_class_e        cls,
   output logic [NIB_W-1:0] nib
);
   localparam int N_DATA = 1 << NIB_W;

   initial begin
      if (SYM_W != 5) $error("rx100_cg_classify: SYM_W must be 5");
      if (NIB_W != 4) $error("rx100_cg_classify: NIB_W must be 4");
   end

   logic [N_DATA-1:0] hit;

   genvar gi;
   generate
      for (gi = 0; gi < N_DATA; gi++) begin : g_match
         assign hit[gi] = (sym == data_code(gi));
      end
   endgenerate

   always_comb begin
      nib = '0;
      for (int i = 0; i < N_DATA; i++) begin
         if (hit[i]) nib = NIB_W'(i);
      end
   end

   always_comb begin
      if (|hit)                   cls = CG_DATA;
      else if (sym == CODE_J)     cls = CG_J;
      else if (sym == CODE_K)     cls = CG_K;
      else if (sym == CODE_T)     cls = CG_T;
      else if (sym == CODE_R)     cls = CG_R;
      else if (sym == CODE_IDLE)  cls = CG_IDLE;
      else                        cls = CG_BAD;
   end

   AST_DATA_UNIQUE: assert final ($onehot0(hit)); // R2

endmodule

// File: rtl/rx100_stream_ctl.sv
module rx100_stream_ctl
   import rx100_pkg::*;
#(
   parameter int               NIB_W       = 4,
   parameter logic [NIB_W-1:0] PRE_NIB     = 4'b0101,
   parameter logic [NIB_W-1:0] SSD_ERR_NIB = 4'b1110,
   parameter int               ERR_NIB_SEL = 0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  cg_class_e        cls,
   input  logic [NIB_W-1:0] dec_nib,
   input  logic [NIB_W-1:0] raw_low,
   output logic             nxt_dv,
   output logic             nxt_er,
   output logic [NIB_W-1:0] nxt_nib,
   output rx_state_e        state
);
   initial begin
      if (ERR_NIB_SEL < 0 || ERR_NIB_SEL > 1)
         $error("rx100_stream_ctl: ERR_NIB_SEL must be 0 or 1");
   end

   logic [NIB_W-1:0] junk_nib;

   generate
      if (ERR_NIB_SEL == 1) begin : g_err_raw
         assign junk_nib = raw_low;
      end else begin : g_err_zero
         assign junk_nib = '0;
      end
   endgenerate

   rx_state_e state_n;

   always_comb begin
      state_n = state;
      nxt_dv  = 1'b0;
      nxt_er  = 1'b0;
      nxt_nib = '0;
      unique case (state)
         ST_HUNT: begin
            if (cls == CG_J) begin
               state_n = ST_SSD2;
            end else if (cls != CG_IDLE) begin
               nxt_er  = 1'b1;
               nxt_nib = SSD_ERR_NIB;
            end
         end
         ST_SSD2: begin
            if (cls == CG_K) begin
               state_n = ST_BODY;
               nxt_dv  = 1'b1;
               nxt_nib = PRE_NIB;
            end else begin
               state_n = ST_HUNT;
               nxt_er  = 1'b1;
               nxt_nib = SSD_ERR_NIB;
            end
         end
         ST_BODY: begin
            if (cls == CG_DATA) begin
               nxt_dv  = 1'b1;
               nxt_nib = dec_nib;
            end else if (cls == CG_T) begin
               state_n = ST_ESD2;
            end else if (cls == CG_IDLE) begin
               state_n = ST_HUNT;
               nxt_dv  = 1'b1;
               nxt_er  = 1'b1;
               nxt_nib = junk_nib;
            end else begin
               nxt_dv  = 1'b1;
               nxt_er  = 1'b1;
               nxt_nib = junk_nib;
            end
         end
         ST_ESD2: begin
            state_n = ST_HUNT;
            if (cls != CG_R) nxt_er = 1'b1;
         end
         default: state_n = ST_HUNT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      state <= ST_HUNT;
      else if (strobe) state <= state_n;
   end

   AST_ESD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && state == ST_ESD2) |=> state == ST_HUNT); // R7

   AST_IDLE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && state == ST_BODY && cls == CG_IDLE) |=> state == ST_HUNT); // R8

endmodule

// File: rtl/rx100_mii_out.sv
module rx100_mii_out #(
   parameter int NIB_W = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             d_dv,
   input  logic             d_er,
   input  logic [NIB_W-1:0] d_nib,
   output logic             q_dv,
   output logic             q_er,
   output logic [NIB_W-1:0] q_nib
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_dv  <= 1'b0;
         q_er  <= 1'b0;
         q_nib <= '0;
      end else if (load) begin
         q_dv  <= d_dv;
         q_er  <= d_er;
         q_nib <= d_nib;
      end
   end
endmodule

// File: rtl/rx100_symbol_decoder.sv
module rx100_symbol_decoder
   import rx100_pkg::*;
#(
   parameter int SYM_W       = 5,
   parameter int NIB_W       = 4,
   parameter int ERR_NIB_SEL = 0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_vld,
   input  logic [SYM_W-1:0] sym_in,
   output logic [NIB_W-1:0] rx_nib,
   output logic             rx_dv,
   output logic             rx_er
);
   localparam logic [NIB_W-1:0] PRE_NIB     = NIB_W'(4'b0101);
   localparam logic [NIB_W-1:0] SSD_ERR_NIB = NIB_W'(4'b1110);

   initial begin
      if (SYM_W != NIB_W + 1) $error("rx100_symbol_decoder: SYM_W must be NIB_W+1");
   end

   cg_class_e        cls;
   logic [NIB_W-1:0] dec_nib;
   logic             nxt_dv, nxt_er;
   logic [NIB_W-1:0] nxt_nib;
   rx_state_e        state;

   rx100_cg_classify #(.SYM_W(SYM_W), .NIB_W(NIB_W)) u_cls (
      .sym (sym_in),
      .cls (cls),
      .nib (dec_nib)
   );

   rx100_stream_ctl #(
      .NIB_W       (NIB_W),
      .PRE_NIB     (PRE_NIB),
      .SSD_ERR_NIB (SSD_ERR_NIB),
      .ERR_NIB_SEL (ERR_NIB_SEL)
   ) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (sym_vld),
      .cls     (cls),
      .dec_nib (dec_nib),
      .raw_low (sym_in[NIB_W-1:0]),
      .nxt_dv  (nxt_dv),
      .nxt_er  (nxt_er),
      .nxt_nib (nxt_nib),
      .state   (state)
   );

   rx100_mii_out #(.NIB_W(NIB_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (sym_vld),
      .d_dv  (nxt_dv),
      .d_er  (nxt_er),
      .d_nib (nxt_nib),
      .q_dv  (rx_dv),
      .q_er  (rx_er),
      .q_nib (rx_nib)
   );

   AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_vld |=> $stable({rx_dv, rx_er, rx_nib})); // R9

   AST_DV_RISE_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_dv) |-> (rx_nib == PRE_NIB && !rx_er)); // R3

   AST_BAD_SSD: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_vld && state == ST_SSD2 && sym_in != CODE_K)
         |=> (rx_er && !rx_dv && rx_nib == SSD_ERR_NIB)); // R4

   AST_ESD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_vld && state == ST_ESD2 && sym_in == CODE_R) |=> (!rx_dv && !rx_er)); // R6

endmodule

// File: tb/tb_rx100_symbol_decoder.sv
`timescale 1ns/1ps
module tb_rx100_symbol_decoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sym_vld = 1'b0;
   logic [4:0] sym_in = 5'b11111;
   logic [3:0] rx_nib;
   logic       rx_dv, rx_er;

   int n_chk = 0;
   int n_bad = 0;

   localparam logic [4:0] SJ = 5'b11000, SK = 5'b10001, ST = 5'b01101,
                          SR = 5'b00111, SH = 5'b11111;

   always #5 clk = ~clk;

   rx100_symbol_decoder dut (
      .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym_in(sym_in),
      .rx_nib(rx_nib), .rx_dv(rx_dv), .rx_er(rx_er)
   );

   function automatic logic [4:0] dc(input int n);
      logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                             5'b01010, 5'b01011, 5'b01110, 5'b01111,
                             5'b10010, 5'b10011, 5'b10110, 5'b10111,
                             5'b11010, 5'b11011, 5'b11100, 5'b11101};
      return t[n];
   endfunction

   task automatic chk(input string tag, input logic edv, input logic eer,
                      input logic [3:0] enib, input bit use_nib);
      n_chk++;
      if (rx_dv !== edv || rx_er !== eer || (use_nib && rx_nib !== enib)) begin
         n_bad++;
         $display("FAIL %s: dv/er/nib = %b/%b/%h, expected %b/%b/%h%s", tag,
                  rx_dv, rx_er, rx_nib, edv, eer, enib, use_nib ? "" : " (nib free)");
      end
   endtask

   // drive one code-group at a negedge, sample at the next negedge
   task automatic step(input logic [4:0] s, input string tag, input logic edv,
                       input logic eer, input logic [3:0] enib, input bit use_nib);
      sym_in  = s;
      sym_vld = 1'b1;
      @(negedge clk);
      sym_vld = 1'b0;
      chk(tag, edv, eer, enib, use_nib);
   endtask

   task automatic t_reset;
      chk("R1 in reset", 0, 0, 4'h0, 1);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", 0, 0, 4'h0, 1);
   endtask

   task automatic t_full_frame;
      step(SH, "R10 idle", 0, 0, 4'h0, 1);
      step(SJ, "R3 J slot", 0, 0, 4'h0, 1);
      step(SK, "R3 K slot", 1, 0, 4'h5, 1);
      for (int i = 0; i < 16; i++) step(dc(i), "R2 data", 1, 0, 4'(i), 1);
      step(ST, "R6 T slot", 0, 0, 4'h0, 1);
      step(SR, "R6 R slot", 0, 0, 4'h0, 1);
      step(SH, "R10 idle after", 0, 0, 4'h0, 1);
   endtask

   task automatic t_bad_ssd;
      step(SJ, "R4 J", 0, 0, 4'h0, 1);
      step(dc(1), "R4 J then data", 0, 1, 4'hE, 1);
      step(dc(2), "R4 junk in hunt", 0, 1, 4'hE, 1);
      step(SJ, "R4 J again", 0, 0, 4'h0, 1);
      step(SJ, "R4 J then J", 0, 1, 4'hE, 1);
      step(SH, "R10 idle", 0, 0, 4'h0, 1);
   endtask

   task automatic t_inframe_err;
      step(SJ, "R5 J", 0, 0, 4'h0, 1);
      step(SK, "R5 K", 1, 0, 4'h5, 1);
      step(dc(3), "R5 data", 1, 0, 4'h3, 1);
      step(SJ, "R5 J in frame", 1, 1, 4'h0, 0);
      step(5'b00000, "R5 bad code", 1, 1, 4'h0, 0);
      step(dc(7), "R5 frame goes on", 1, 0, 4'h7, 1);
      step(ST, "R6 T", 0, 0, 4'h0, 1);
      step(SR, "R6 R", 0, 0, 4'h0, 1);
      step(SH, "R10 idle", 0, 0, 4'h0, 1);
   endtask

   task automatic t_bad_esd;
      step(SJ, "R7 J", 0, 0, 4'h0, 1);
      step(SK, "R7 K", 1, 0, 4'h5, 1);
      step(dc(9), "R7 data", 1, 0, 4'h9, 1);
      step(ST, "R7 T", 0, 0, 4'h0, 1);
      step(dc(9), "R7 T then data", 0, 1, 4'h0, 1);
      step(dc(4), "R7 back in hunt", 0, 1, 4'hE, 1);
      step(SH, "R10 idle", 0, 0, 4'h0, 1);
   endtask

   task automatic t_idle_mid;
      step(SJ, "R8 J", 0, 0, 4'h0, 1);
      step(SK, "R8 K", 1, 0, 4'h5, 1);
      step(dc(2), "R8 data", 1, 0, 4'h2, 1);
      step(SH, "R8 idle in frame", 1, 1, 4'h0, 0);
      step(dc(1), "R8 data not delivered", 0, 1, 4'hE, 1);
      step(SH, "R10 idle", 0, 0, 4'h0, 1);
   endtask

   task automatic t_hold;
      step(SJ, "R9 J", 0, 0, 4'h0, 1);
      step(SK, "R9 K", 1, 0, 4'h5, 1);
      for (int i = 0; i < 3; i++) begin
         sym_in = (i == 0) ? SH : ST;
         @(negedge clk);
         chk("R9 hold without strobe", 1, 0, 4'h5, 1);
      end
      step(dc(10), "R9 data after gap", 1, 0, 4'hA, 1);
      step(ST, "R9 T", 0, 0, 4'h0, 1);
      step(SR, "R9 R", 0, 0, 4'h0, 1);
   endtask

   initial begin
      #100_000;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_full_frame();
      t_bad_ssd();
      t_inframe_err();
      t_bad_esd();
      t_idle_mid();
      t_hold();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule